// File: doc/BRIEF.md
# Schedule Timer with Alarm Compare

This block is a 16-bit schedule counter paired with a 16-bit alarm compare value, reached through a small register port. The port has an address, write data, a write strobe and combinational read data. A control word holds a count enable, a sync-clear enable, an alarm enable and a sticky alarm flag. While the count enable is set, the counter steps by one on each prescaler tick. It restarts from zero in two cases: when a synchronized rising edge arrives on the external event input and sync-clear is enabled, or when the alarm is enabled and the counter equals the alarm value at a tick. An alarm match also latches the flag.

Software can read and load the counter at any time. The alarm value only accepts writes while the counter or the alarm is enabled. The external event input may be asynchronous; it passes through a two-flop synchronizer before its rising edge is detected. All state is cleared by a synchronous active-high reset.

Top module: `sched_timer`

## Requirements
- R1: After reset the counter, the alarm value and the whole control word read back as zero.
- R2: With count enable (control bit 0) set, each cycle with `tick_i` high adds one to the counter, and 16'hFFFF steps to 16'h0000.
- R3: With count enable clear, the counter holds its value through ticks, sync edges and alarm matches, and a match in that state does not set the flag.
- R4: With count enable and sync-clear enable (control bit 1) set, a rising edge of `sync_i` clears the counter. A `sync_i` held high clears the counter once, after the third rising clock edge counted from the edge that first samples it high. With sync-clear enable at 0 the edge has no effect.
- R5: With count enable and alarm enable (control bit 2) set, a tick on which the counter equals the alarm value loads zero in place of the increment and sets the alarm flag (control bit 3). Starting from zero with alarm value A, after n ticks the counter reads n mod (A+1).
- R6: The alarm flag stays set until a control write with bit 3 at 0. Writing 1 to bit 3 never sets it. A match in the same cycle as a clearing write leaves the flag set.
- R7: A write to the alarm value takes effect only while count enable or alarm enable is set. At other times the write is dropped and the old value is kept.
- R8: A counter write loads the write data. It takes precedence over an increment on the same cycle, and a sync or alarm clear on the same cycle takes precedence over the write.
- R9: The read map is: address 0 returns {12'b0, flag, alarm enable, sync-clear enable, count enable}, address 1 the counter, address 2 the alarm value, and address 3 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle prescaler tick |
| sync_i | input | 1 | External synchronization event, may be asynchronous |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 16 | Read data for `reg_addr` |

## Verification
The assertions take for granted that `tick_i` and `reg_we` are synchronous to `clk`, and that `sync_i` is only seen through the synchronizer, so its timing relative to the clock never reaches the counter directly. The bench drives every input on the falling clock edge and holds each write or tick for exactly one rising edge. It raises `sync_i` only while the register port and the tick are idle, so each clear can be traced to a single cause. The bench sweeps alarm values 0 to 9 against up to 20 ticks and predicts each counter and flag value with modulo arithmetic.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_ALM  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Control word; field positions are part of the read/write map.
    typedef struct packed {
        logic flag;
        logic alm_en;
        logic sync_en;
        logic cnt_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Counter command for one cycle.
    typedef struct packed {
        logic clr;
        logic load;
        logic step;
    } cnt_cmd_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_W-1:0] = c;
        return w;
    endfunction

    function automatic cnt_cmd_t pick_cmd(input logic en, input logic clr_req,
                                          input logic wr, input logic tick);
        cnt_cmd_t c;
        c = '0;
        if (en && clr_req) begin
            c.clr = 1'b1;
        end else if (wr) begin
            c.load = 1'b1;
        end else if (en && tick) begin
            c.step = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/sched_sync_edge.sv
module sched_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], async_i};
        end
    end

    assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R4

endmodule

// File: rtl/sched_counter.sv
module sched_counter
    import sched_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic         sync_en_i,
    input  logic         sync_rise_i,
    input  logic         alm_en_i,
    input  logic [W-1:0] alm_val_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    logic [W-1:0] cnt_q;
    logic         hit;
    logic         clr_req;
    cnt_cmd_t     cmd;

    assign hit     = alm_en_i && tick_i && (cnt_q == alm_val_i);
    assign clr_req = hit || (sync_en_i && sync_rise_i);
    assign cmd     = pick_cmd(en_i, clr_req, wr_i, tick_i);
    assign match_o = en_i && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (1'b1)
                cmd.clr:  cnt_q <= '0;
                cmd.load: cnt_q <= wdata_i;
                cmd.step: cnt_q <= cnt_q + 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (en_i && tick_i && !wr_i && !alm_en_i && !sync_en_i) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !wr_i) |=> $stable(cnt_q)); // R3
    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_i && sync_en_i && sync_rise_i) |=> cnt_q == '0); // R4
    AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_i && alm_en_i && tick_i && cnt_q == alm_val_i) |=> cnt_q == '0); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !(en_i && clr_req)) |=> cnt_q == $past(wdata_i)); // R8
    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd)); // R8

endmodule

// File: rtl/sched_regs.sv
module sched_regs
    import sched_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ctrl_i,
    input  logic         wr_alm_i,
    input  logic [W-1:0] wdata_i,
    input  logic         match_i,
    output ctrl_t        ctrl_o,
    output logic [W-1:0] alm_o
);
    ctrl_t        ctrl_q;
    logic [W-1:0] alm_q;
    logic         alm_open;
    logic         flag_wipe;

    assign alm_open  = ctrl_q.cnt_en || ctrl_q.alm_en;
    assign flag_wipe = wr_ctrl_i && !wdata_i[CTRL_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            alm_q  <= '0;
        end else begin
            if (wr_ctrl_i) begin
                ctrl_q.cnt_en  <= wdata_i[0];
                ctrl_q.sync_en <= wdata_i[1];
                ctrl_q.alm_en  <= wdata_i[2];
            end
            ctrl_q.flag <= match_i || (ctrl_q.flag && !flag_wipe);
            if (wr_alm_i && alm_open) begin
                alm_q <= wdata_i;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign alm_o  = alm_q;

    AST_ALM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_alm_i && !ctrl_q.cnt_en && !ctrl_q.alm_en) |=> $stable(alm_q)); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        match_i |=> ctrl_q.flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !wr_ctrl_i) |=> ctrl_q.flag); // R6
    AST_FLAG_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.flag && !match_i) |=> !ctrl_q.flag); // R6

endmodule

// File: rtl/sched_timer.sv
module sched_timer
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              sync_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata
);
    reg_sel_e          sel;
    logic              wr_ctrl;
    logic              wr_cnt;
    logic              wr_alm;
    logic              sync_rise;
    logic              match;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] alm;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_ctrl = reg_we && (sel == SEL_CTRL);
    assign wr_cnt  = reg_we && (sel == SEL_CNT);
    assign wr_alm  = reg_we && (sel == SEL_ALM);

    sched_sync_edge #(.STAGES(2)) sync_i0 (
        .clk     (clk),
        .rst     (rst),
        .async_i (sync_i),
        .rise_o  (sync_rise)
    );

    sched_regs #(.W(DATA_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl_i (wr_ctrl),
        .wr_alm_i  (wr_alm),
        .wdata_i   (reg_wdata),
        .match_i   (match),
        .ctrl_o    (ctrl),
        .alm_o     (alm)
    );

    sched_counter #(.W(DATA_W)) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl.cnt_en),
        .tick_i      (tick_i),
        .sync_en_i   (ctrl.sync_en),
        .sync_rise_i (sync_rise),
        .alm_en_i    (ctrl.alm_en),
        .alm_val_i   (alm),
        .wr_i        (wr_cnt),
        .wdata_i     (reg_wdata),
        .cnt_o       (cnt),
        .match_o     (match)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = ctrl_to_word(ctrl);
            SEL_CNT:  reg_rdata = cnt;
            SEL_ALM:  reg_rdata = alm;
            default:  reg_rdata = '0;
        endcase
    end

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt == '0 && alm == '0 && ctrl == '0)); // R1
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> reg_rdata == '0); // R9

endmodule

// File: tb/sched_timer_tb.sv
module sched_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        sync_i = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sched_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .sync_i    (sync_i),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    // One rising edge with the given write and tick.
    task automatic cyc(input bit we, input logic [1:0] a, input logic [15:0] d, input bit tk);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; tick_i = tk;
        @(negedge clk);
        reg_we = 1'b0; tick_i = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'd0, 1'b0);
    endtask

    task automatic chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", 2'd0, 16'h0000);
        chk("R1", 2'd1, 16'h0000);
        chk("R1", 2'd2, 16'h0000);

        // R9 spare address
        chk("R9", 2'd3, 16'h0000);

        // R7 alarm locked while both enables clear
        wr(2'd2, 16'hBEEF);
        chk("R7", 2'd2, 16'h0000);
        wr(2'd0, 16'h0004);
        wr(2'd2, 16'h1111);
        chk("R7", 2'd2, 16'h1111);
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h2222);
        chk("R7", 2'd2, 16'h2222);
        chk("R9", 2'd0, 16'h0001);

        // R2 wrap
        wr(2'd1, 16'hFFFE);
        cyc(1'b0, 2'd0, 16'd0, 1'b1);
        chk("R2", 2'd1, 16'hFFFF);
        cyc(1'b0, 2'd0, 16'd0, 1'b1);
        chk("R2", 2'd1, 16'h0000);
        for (int i = 1; i <= 5; i++) begin
            cyc(1'b0, 2'd0, 16'd0, 1'b1);
            chk("R2", 2'd1, 16'(i));
        end

        // R8 write beats increment
        cyc(1'b1, 2'd1, 16'h0100, 1'b1);
        chk("R8", 2'd1, 16'h0100);

        // R5 / R6 sweep: counter = n mod (A+1), flag when n > A
        for (int a = 0; a < 10; a++) begin
            wr(2'd0, 16'h0004);
            wr(2'd2, 16'(a));
            wr(2'd1, 16'h0000);
            wr(2'd0, 16'h0005);
            for (int n = 1; n <= 20; n++) begin
                cyc(1'b0, 2'd0, 16'd0, 1'b1);
                chk("R5", 2'd1, 16'(n % (a + 1)));
                chk("R6", 2'd0, (n > a) ? 16'h000D : 16'h0005);
            end
        end

        // R6 write 1 to flag does not set; write 0 clears
        wr(2'd0, 16'h0005);
        chk("R6", 2'd0, 16'h0005);
        wr(2'd0, 16'h000D);
        chk("R6", 2'd0, 16'h0005);

        // R6 match beats clearing write; flag then cleared alone
        wr(2'd2, 16'h0007);
        wr(2'd1, 16'h0007);
        wr(2'd0, 16'h0005);
        cyc(1'b1, 2'd0, 16'h0005, 1'b1);
        chk("R6", 2'd0, 16'h000D);
        chk("R5", 2'd1, 16'h0000);
        wr(2'd0, 16'h0005);
        chk("R6", 2'd0, 16'h0005);

        // R8 clear beats counter write
        wr(2'd1, 16'h0007);
        cyc(1'b1, 2'd1, 16'h0077, 1'b1);
        chk("R8", 2'd1, 16'h0000);
        chk("R6", 2'd0, 16'h000D);

        // R3 disabled: tick, match, sync do nothing
        wr(2'd0, 16'h0006);
        wr(2'd1, 16'h0007);
        cyc(1'b0, 2'd0, 16'd0, 1'b1);
        chk("R3", 2'd1, 16'h0007);
        chk("R3", 2'd0, 16'h0006);
        @(negedge clk); sync_i = 1'b1;
        idle(4);
        chk("R3", 2'd1, 16'h0007);
        @(negedge clk); sync_i = 1'b0;
        idle(3);

        // R4 sync disabled: no clear
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0042);
        @(negedge clk); sync_i = 1'b1;
        idle(4);
        chk("R4", 2'd1, 16'h0042);
        @(negedge clk); sync_i = 1'b0;
        idle(3);

        // R4 sync enabled: exact latency and single clear
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'h1234);
        @(negedge clk); sync_i = 1'b1;
        @(negedge clk); // edge 1 samples
        chk("R4", 2'd1, 16'h1234);
        @(negedge clk); // edge 2
        chk("R4", 2'd1, 16'h1234);
        @(negedge clk); // edge 3 clears
        chk("R4", 2'd1, 16'h0000);
        wr(2'd1, 16'h0055);
        idle(3);
        chk("R4", 2'd1, 16'h0055);
        @(negedge clk); sync_i = 1'b0;
        idle(3);
        chk("R4", 2'd1, 16'h0055);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", 2'd0, 16'h0000);
        chk("R1", 2'd1, 16'h0000);
        chk("R1", 2'd2, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule